// File: doc/BRIEF.md
# Paged Nonvolatile Write Buffer Controller

This block is the write side of a paged nonvolatile store. It keeps one page of the backing array resident in a page buffer. It also keeps one block of that page in a smaller block buffer, where single-word edits land. A host issues writes on a simple strobe interface. The controller decides whether the write hits the block being edited, needs a block swap within the resident page, or needs the whole page copied in from the array. It holds a registered busy flag for exactly as long as each case needs.

Errors are judged in the cycle a write is accepted. A write to a locked page, or a write that would evict the resident page while loss protection is on, is refused. The refusal costs no busy cycles and leaves both buffers untouched. A two-bit result code reports the outcome and holds it until the next accepted write. The backing array is a small generated read-only image. A peek port gives a combinational view of the current buffered contents, so written data can be observed without a full read path.

Top module: `nvw_write_ctrl`

## Requirements
- R1: After reset, busy is 0, status is 00, no page is resident, and every peeked word reads 0.
- R2: Some writes have no error and target a page that is not resident. Busy rises in the cycle after acceptance and stays high for exactly 55 cycles. Afterwards the whole page reads back as the array image, except for the written word. The image word for page p, block b and word w is {p[7:0], b[7:0], w[7:0], 8'h3C}.
- R3: A write that has no error and targets the block currently being edited causes no busy cycles. The new data is visible on the peek port one cycle after acceptance.
- R4: Some writes target a different block of the resident page while pipe mode is low. These writes hold busy for exactly 4 cycles. The previously edited block stays in the page buffer with its edits.
- R5: The same block switch with pipe mode high holds busy for exactly 5 cycles.
- R6: A write whose page has its bit set in the page lock vector gives status 01. It causes no busy cycles and changes no buffered data. Lock takes precedence over loss protection.
- R7: Some writes target a non-resident page while loss protection is high and the page is not locked. These writes give status 11, cause no busy cycles and change no buffered data. The resident page stays resident.
- R8: Status changes only when a write is accepted. Every accepted write without an error sets it to 00.
- R9: A write strobe raised while busy is 1 is ignored.
- R10: The size code selects the write width. Code 00 is a byte: wr_data[7:0] goes to the lane given by address bits [1:0]. Code 01 is a halfword: wr_data[15:0] goes to the lower lanes if address bit 1 is 0 and the upper lanes if it is 1. Codes 10 and 11 write the whole 32-bit word. Lanes that are not written keep their value.
- R11: The address is split into fields. Address bits [10:9] select the page. Bits [8:5] select the block, reduced modulo 9. Bits [4:2] select the word, and bits [1:0] the byte lane. Bits [17:11] have no effect.
- R12: A successful write to a different page, with loss protection low, discards the edits made to the previously resident page. When that page is loaded again, it reads back as the array image.
- R13: The peek index is block*8+word. It returns the word as currently buffered, taking the block buffer for the block being edited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, accepted when busy is 0 |
| wr_addr | input | 18 | Byte address (page, block, word, lane) |
| wr_data | input | 32 | Write data |
| wr_size | input | 2 | Width code: 00 byte, 01 halfword, 1x word |
| pipe_mode | input | 1 | Adds one cycle to a block switch |
| loss_guard | input | 1 | Refuse writes that would evict the resident page |
| page_lock | input | 4 | Per-page lock vector, bit n locks page n |
| peek_idx | input | 7 | Buffered word index, block*8+word |
| busy | output | 1 | Registered busy flag |
| status | output | 2 | Sticky result code: 00 ok, 01 locked, 11 page loss |
| peek_data | output | 32 | Buffered word at peek_idx |

## Verification
The bench measures the exact busy length for a page miss, a plain block switch and a pipelined block switch. A design that miscounts the copy phases shows 54 or 56 busy cycles. A design that forgets the pipe cycle shows 4 where 5 are due. Each refused write is followed by a peek of words near the target. A design that writes before checking the lock or loss condition shows corrupted data, or busy pulses where none should occur. Byte and halfword writes are placed on different lanes, and the address has its high bits set or its block field out of range, which exposes wrong lane masks or wrong field slicing. A strobe raised in the middle of a page copy, and a return to a page whose edits were lost, show whether a design queues stray writes or keeps data it should have dropped.

// File: rtl/nvw_pkg.sv
package nvw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COPY,
        ST_LOAD,
        ST_SWITCH
    } ctrl_state_e;

    localparam logic [1:0] RES_OK     = 2'b00;
    localparam logic [1:0] RES_LOCKED = 2'b01;
    localparam logic [1:0] RES_LOST   = 2'b11;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_HALF = 2'b01;

    localparam logic [7:0] IMAGE_TAG = 8'h3C;

endpackage

// File: rtl/nvw_pattern_rom.sv
module nvw_pattern_rom #(
    parameter int PG_W   = 2,
    parameter int BF_W   = 4,
    parameter int WORDS  = 8,
    parameter int DATA_W = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [PG_W-1:0]                  page,
    input  logic [BF_W-1:0]                  blk,
    output logic [WORDS-1:0][DATA_W-1:0]     blk_q
);
    import nvw_pkg::*;

    logic [WORDS-1:0][DATA_W-1:0] blk_d;

    // The array image is generated from its coordinates, one word per lane slot.
    always_comb begin
        for (int w = 0; w < WORDS; w++) begin
            blk_d[w] = DATA_W'({8'(page), 8'(blk), 8'(w), IMAGE_TAG});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= '0;
        end else begin
            blk_q <= blk_d;
        end
    end

endmodule

// File: rtl/nvw_lane_merge.sv
module nvw_lane_merge #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 2
) (
    input  logic [DATA_W-1:0] old_word,
    input  logic [DATA_W-1:0] new_data,
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    output logic [DATA_W-1:0] merged
);
    import nvw_pkg::*;

    localparam int LANES = DATA_W / 8;

    logic [LANES-1:0]  lane_en;
    logic [DATA_W-1:0] spread;

    always_comb begin
        lane_en = '0;
        spread  = new_data;
        if (size == SZ_BYTE) begin
            lane_en[lane] = 1'b1;
            spread        = {LANES{new_data[7:0]}};
        end else if (size == SZ_HALF) begin
            for (int l = 0; l < LANES; l++) begin
                lane_en[l] = ((l / 2) == int'(lane[LANE_W-1:1]));
            end
            spread = {(LANES/2){new_data[15:0]}};
        end else begin
            lane_en = '1;
        end
    end

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            assign merged[g*8 +: 8] = lane_en[g] ? spread[g*8 +: 8] : old_word[g*8 +: 8];
        end
    endgenerate

endmodule

// File: rtl/nvw_write_ctrl.sv
module nvw_write_ctrl #(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 32,
    parameter int PAGES      = 4,
    parameter int BLOCKS     = 9,
    parameter int WORDS      = 8,
    parameter int RD_CYC     = 5,
    parameter int SW_CYC     = 4,
    parameter int PEEK_W     = $clog2(BLOCKS*WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        wr_size,
    input  logic              pipe_mode,
    input  logic              loss_guard,
    input  logic [PAGES-1:0]  page_lock,
    input  logic [PEEK_W-1:0] peek_idx,
    output logic              busy,
    output logic [1:0]        status,
    output logic [DATA_W-1:0] peek_data
);
    import nvw_pkg::*;

    localparam int LANE_W  = $clog2(DATA_W/8);
    localparam int WD_W    = $clog2(WORDS);
    localparam int BF_W    = $clog2(BLOCKS);
    localparam int PG_W    = $clog2(PAGES);
    localparam int WD_LO   = LANE_W;
    localparam int BF_LO   = WD_LO + WD_W;
    localparam int PG_LO   = BF_LO + BF_W;
    localparam int ADDR_HI = PG_LO + PG_W;
    localparam int PH_W    = $clog2(RD_CYC + 1);
    localparam int CNT_W   = (PH_W > $clog2(SW_CYC + 1)) ? PH_W : $clog2(SW_CYC + 1);

    typedef logic [WORDS-1:0][DATA_W-1:0] blk_t;

    typedef struct packed {
        ctrl_state_e              state;
        logic [CNT_W-1:0]         cnt;
        logic [BF_W-1:0]          blk_cnt;
        logic                     page_ok;
        logic [PG_W-1:0]          res_page;
        logic [BF_W-1:0]          cur_blk;
        logic [PG_W-1:0]          pend_page;
        logic [BF_W-1:0]          pend_blk;
        logic [WD_W-1:0]          pend_wd;
        logic [LANE_W-1:0]        pend_lane;
        logic [1:0]               pend_size;
        logic [DATA_W-1:0]        pend_data;
        logic [BLOCKS-1:0][WORDS-1:0][DATA_W-1:0] pbuf;
        blk_t                     bbuf;
        blk_t                     blkreg;
        logic                     busy;
        logic [1:0]               status;
    } ctrl_t;

    ctrl_t d, q;

    // Request decode
    logic [PG_W-1:0]   in_pg;
    logic [BF_W-1:0]   in_blk;
    logic [WD_W-1:0]   in_wd;
    logic [LANE_W-1:0] in_lane;
    logic              accept;
    logic              resident;

    assign in_pg   = wr_addr[PG_LO +: PG_W];
    assign in_blk  = BF_W'(32'(wr_addr[BF_LO +: BF_W]) % BLOCKS);
    assign in_wd   = wr_addr[WD_LO +: WD_W];
    assign in_lane = wr_addr[0 +: LANE_W];
    assign accept  = wr_en && !q.busy;
    assign resident = q.page_ok && (q.res_page == in_pg);

    logic unused_hi_addr;
    assign unused_hi_addr = ^wr_addr[ADDR_W-1:ADDR_HI];

    // Array image
    blk_t rom_q;

    nvw_pattern_rom #(
        .PG_W   (PG_W),
        .BF_W   (BF_W),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_rom (
        .clk   (clk),
        .rst_n (rst_n),
        .page  (q.pend_page),
        .blk   (q.blk_cnt),
        .blk_q (rom_q)
    );

    // Single lane merge shared by the direct and deferred write paths
    logic [DATA_W-1:0] m_old;
    logic [DATA_W-1:0] m_data;
    logic [1:0]        m_size;
    logic [LANE_W-1:0] m_lane;
    logic [DATA_W-1:0] m_new;

    always_comb begin
        if (q.state == ST_IDLE) begin
            m_old  = q.bbuf[in_wd];
            m_data = wr_data;
            m_size = wr_size;
            m_lane = in_lane;
        end else begin
            m_old  = q.pbuf[q.pend_blk][q.pend_wd];
            m_data = q.pend_data;
            m_size = q.pend_size;
            m_lane = q.pend_lane;
        end
    end

    nvw_lane_merge #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_merge (
        .old_word (m_old),
        .new_data (m_data),
        .size     (m_size),
        .lane     (m_lane),
        .merged   (m_new)
    );

    // Next-state logic
    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    d.pend_page = in_pg;
                    d.pend_blk  = in_blk;
                    d.pend_wd   = in_wd;
                    d.pend_lane = in_lane;
                    d.pend_size = wr_size;
                    d.pend_data = wr_data;
                    if (page_lock[in_pg]) begin
                        d.status = RES_LOCKED;
                    end else if (!resident) begin
                        if (loss_guard) begin
                            d.status = RES_LOST;
                        end else begin
                            d.status  = RES_OK;
                            d.state   = ST_COPY;
                            d.cnt     = '0;
                            d.blk_cnt = '0;
                            d.page_ok = 1'b0;
                        end
                    end else if (in_blk == q.cur_blk) begin
                        d.status       = RES_OK;
                        d.bbuf[in_wd]  = m_new;
                    end else begin
                        d.status = RES_OK;
                        d.state  = ST_SWITCH;
                        d.cnt    = pipe_mode ? CNT_W'(SW_CYC) : CNT_W'(SW_CYC - 1);
                    end
                end
            end
            ST_COPY: begin
                if (q.cnt == CNT_W'(RD_CYC - 1)) begin
                    d.blkreg = rom_q;
                end
                if (q.cnt == CNT_W'(RD_CYC)) begin
                    d.pbuf[q.blk_cnt] = q.blkreg;
                    d.cnt             = '0;
                    if (q.blk_cnt == BF_W'(BLOCKS - 1)) begin
                        d.state = ST_LOAD;
                    end else begin
                        d.blk_cnt = q.blk_cnt + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_LOAD: begin
                d.bbuf            = q.pbuf[q.pend_blk];
                d.bbuf[q.pend_wd] = m_new;
                d.cur_blk         = q.pend_blk;
                d.res_page        = q.pend_page;
                d.page_ok         = 1'b1;
                d.state           = ST_IDLE;
            end
            ST_SWITCH: begin
                if (q.cnt == '0) begin
                    d.pbuf[q.cur_blk] = q.bbuf;
                    d.bbuf            = q.pbuf[q.pend_blk];
                    d.bbuf[q.pend_wd] = m_new;
                    d.cur_blk         = q.pend_blk;
                    d.state           = ST_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
        d.busy = (d.state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // Peek view
    logic [PEEK_W-WD_W-1:0] pk_blk;
    logic [WD_W-1:0]        pk_wd;

    assign pk_blk = peek_idx[PEEK_W-1:WD_W];
    assign pk_wd  = peek_idx[WD_W-1:0];

    always_comb begin
        if (32'(pk_blk) >= BLOCKS) begin
            peek_data = '0;
        end else if (q.page_ok && (32'(pk_blk) == 32'(q.cur_blk))) begin
            peek_data = q.bbuf[pk_wd];
        end else begin
            peek_data = q.pbuf[pk_blk][pk_wd];
        end
    end

    assign busy   = q.busy;
    assign status = q.status;

    // Observation points for the bound checker
    logic            res_valid;
    logic [PG_W-1:0] res_page;
    logic [BF_W-1:0] cur_blk;

    assign res_valid = q.page_ok;
    assign res_page  = q.res_page;
    assign cur_blk   = q.cur_blk;

endmodule

// File: rtl/nvw_write_ctrl_chk.sv
module nvw_write_ctrl_chk #(
    parameter int ADDR_W = 18,
    parameter int PAGES  = 4,
    parameter int BLOCKS = 9,
    parameter int WORDS  = 8,
    parameter int LANE_W = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic                       loss_guard,
    input logic [PAGES-1:0]           page_lock,
    input logic                       busy,
    input logic [1:0]                 status,
    input logic                       res_valid,
    input logic [$clog2(PAGES)-1:0]   res_page,
    input logic [$clog2(BLOCKS)-1:0]  cur_blk
);
    localparam int PG_W  = $clog2(PAGES);
    localparam int BF_W  = $clog2(BLOCKS);
    localparam int BF_LO = LANE_W + $clog2(WORDS);
    localparam int PG_LO = BF_LO + BF_W;

    logic [PG_W-1:0] c_pg;
    logic [BF_W-1:0] c_blk;
    logic            c_acc;
    logic            c_res;

    assign c_pg  = wr_addr[PG_LO +: PG_W];
    assign c_blk = BF_W'(32'(wr_addr[BF_LO +: BF_W]) % BLOCKS);
    assign c_acc = wr_en && !busy;
    assign c_res = res_valid && (res_page == c_pg);

    // R6
    locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_acc && page_lock[c_pg] |=> (status == 2'b01) && !busy);

    // R7
    lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_acc && !page_lock[c_pg] && loss_guard && !c_res |=> (status == 2'b11) && !busy);

    // R3
    same_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_acc && !page_lock[c_pg] && c_res && (c_blk == cur_blk) |=> !busy && (status == 2'b00));

    // R2
    miss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_acc && !page_lock[c_pg] && !loss_guard && !c_res |=> busy);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !c_acc |=> $stable(status));

    // R2 R4 R5: every busy run has one of the allowed lengths
    logic [7:0] run_q;
    logic       busy_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q       <= '0;
            busy_prev_q <= 1'b0;
        end else begin
            run_q       <= busy ? run_q + 8'd1 : 8'd0;
            busy_prev_q <= busy;
            if (busy_prev_q && !busy) begin
                run_len_chk: assert (run_q == 8'd4 || run_q == 8'd5 || run_q == 8'd55);
            end
        end
    end

endmodule

bind nvw_write_ctrl nvw_write_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .PAGES  (PAGES),
    .BLOCKS (BLOCKS),
    .WORDS  (WORDS),
    .LANE_W (LANE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .loss_guard (loss_guard),
    .page_lock  (page_lock),
    .busy       (busy),
    .status     (status),
    .res_valid  (res_valid),
    .res_page   (res_page),
    .cur_blk    (cur_blk)
);

// File: tb/test_nvw_write_ctrl.sv
module test_nvw_write_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [17:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  wr_size = '0;
    logic        pipe_mode = 1'b0;
    logic        loss_guard = 1'b0;
    logic [3:0]  page_lock = '0;
    logic [6:0]  peek_idx = '0;
    logic        busy;
    logic [1:0]  status;
    logic [31:0] peek_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nvw_write_ctrl i_nvw_write_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_size    (wr_size),
        .pipe_mode  (pipe_mode),
        .loss_guard (loss_guard),
        .page_lock  (page_lock),
        .peek_idx   (peek_idx),
        .busy       (busy),
        .status     (status),
        .peek_data  (peek_data)
    );

    typedef struct packed {
        logic [17:0] addr;
        logic [31:0] data;
        logic [1:0]  size;
        logic        pipe;
        logic        guard;
        logic [3:0]  lock;
        logic [7:0]  exp_busy;
        logic [1:0]  exp_st;
        logic [6:0]  pk;
        logic [31:0] exp_pk;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        // R2 page miss, word write, page1 blk2 w3
        '{18'h0024C, 32'hDEADBEEF, 2'b10, 1'b0, 1'b0, 4'h0, 8'd55, 2'b00, 7'd19, 32'hDEADBEEF, 8'd2},
        // R3 R10 same block, byte lane 1
        '{18'h00241, 32'h000000AB, 2'b00, 1'b0, 1'b0, 4'h0, 8'd0,  2'b00, 7'd16, 32'h0102AB3C, 8'd10},
        // R10 halfword upper half, word 5
        '{18'h00256, 32'h00001234, 2'b01, 1'b0, 1'b0, 4'h0, 8'd0,  2'b00, 7'd21, 32'h1234053C, 8'd10},
        // R4 block switch to blk4 with pipe low
        '{18'h00280, 32'h11111111, 2'b10, 1'b0, 1'b0, 4'h0, 8'd4,  2'b00, 7'd32, 32'h11111111, 8'd4},
        // R5 block switch to blk7 with pipe high, size 11
        '{18'h002E4, 32'h22222222, 2'b11, 1'b1, 1'b0, 4'h0, 8'd5,  2'b00, 7'd57, 32'h22222222, 8'd5},
        // R6 locked page refused
        '{18'h002E8, 32'hFFFFFFFF, 2'b10, 1'b0, 1'b0, 4'h2, 8'd0,  2'b01, 7'd58, 32'h0107023C, 8'd6},
        // R7 loss guard refuses page3
        '{18'h00600, 32'hFFFFFFFF, 2'b10, 1'b0, 1'b1, 4'h0, 8'd0,  2'b11, 7'd0,  32'h0100003C, 8'd7},
        // R6 lock wins over loss guard
        '{18'h00600, 32'hFFFFFFFF, 2'b10, 1'b0, 1'b1, 4'h8, 8'd0,  2'b01, 7'd0,  32'h0100003C, 8'd6},
        // R8 success clears status, byte lane 3
        '{18'h002EB, 32'h00000077, 2'b00, 1'b0, 1'b0, 4'h0, 8'd0,  2'b00, 7'd58, 32'h7707023C, 8'd8},
        // R11 high address bits ignored, back to blk2
        '{18'h3FA4C, 32'hCAFEF00D, 2'b10, 1'b0, 1'b0, 4'h0, 8'd4,  2'b00, 7'd19, 32'hCAFEF00D, 8'd11},
        // R2 switch to page2
        '{18'h00400, 32'h0BADC0DE, 2'b10, 1'b0, 1'b0, 4'h0, 8'd55, 2'b00, 7'd0,  32'h0BADC0DE, 8'd2},
        // R12 back to page1, earlier edits lost
        '{18'h00204, 32'h00000005, 2'b10, 1'b0, 1'b0, 4'h0, 8'd55, 2'b00, 7'd19, 32'h0102033C, 8'd12},
        // R11 block field 12 maps to blk3
        '{18'h00380, 32'h00000099, 2'b10, 1'b0, 1'b0, 4'h0, 8'd4,  2'b00, 7'd24, 32'h00000099, 8'd11}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [6:0] idx, output logic [31:0] val);
        peek_idx = idx;
        #1;
        val = peek_data;
    endtask

    // Drive one write at a falling edge, then count busy cycles.
    task automatic do_write(input vec_t v, output int nbusy);
        wr_addr    = v.addr;
        wr_data    = v.data;
        wr_size    = v.size;
        pipe_mode  = v.pipe;
        loss_guard = v.guard;
        page_lock  = v.lock;
        wr_en      = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        nbusy = 0;
        while (busy && nbusy < 200) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] pv;
        int          nb;
        string       tag;

        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 status", 32'(status), 32'd0);
        peek(7'd19, pv);
        chk("R1 peek", pv, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after release", 32'(busy), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i], nb);
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            chk({tag, " busy"}, 32'(nb), 32'(VEC[i].exp_busy));
            chk({tag, " status"}, 32'(status), 32'(VEC[i].exp_st));
            peek(VEC[i].pk, pv);
            chk({tag, " data"}, pv, VEC[i].exp_pk);
        end

        // R4 R13 committed block keeps edits after switches (blk3 now edited, blk4 in page buffer)
        peek(7'd32, pv);
        chk("R4 committed blk untouched by reload", pv, 32'h0104003C);

        // R9 strobe during a page copy is ignored
        page_lock = 4'h0; loss_guard = 1'b0; pipe_mode = 1'b0;
        wr_addr = 18'h00000; wr_data = 32'hAAAAAAAA; wr_size = 2'b10; wr_en = 1'b1;
        @(negedge clk);
        wr_addr = 18'h00004; wr_data = 32'hBBBBBBBB; wr_en = 1'b1;
        nb = 0;
        while (busy && nb < 200) begin
            nb++;
            @(negedge clk);
            wr_en = 1'b0;
        end
        wr_en = 1'b0;
        chk("R9 busy run", 32'(nb), 32'd55);
        peek(7'd0, pv);
        chk("R9 first write kept", pv, 32'hAAAAAAAA);
        peek(7'd1, pv);
        chk("R9 second write ignored", pv, 32'h0000013C);
        chk("R9 status", 32'(status), 32'd0);

        // R8 error code is sticky through idle cycles
        page_lock = 4'h1;
        do_write('{18'h00008, 32'h12345678, 2'b10, 1'b0, 1'b0, 4'h1, 8'd0, 2'b01, 7'd2, 32'h0, 8'd8}, nb);
        repeat (6) @(negedge clk);
        chk("R8 sticky status", 32'(status), 32'd1);
        chk("R8 no busy", 32'(nb), 32'd0);
        peek(7'd2, pv);
        chk("R6 locked data unchanged", pv, 32'h0000023C);

        // R10 halfword lower half, byte lane 0
        page_lock = 4'h0;
        do_write('{18'h00008, 32'h0000ABCD, 2'b01, 1'b0, 1'b0, 4'h0, 8'd0, 2'b00, 7'd2, 32'h0, 8'd10}, nb);
        peek(7'd2, pv);
        chk("R10 lower half", pv, 32'h0000ABCD);
        do_write('{18'h0000C, 32'h000000EE, 2'b00, 1'b0, 1'b0, 4'h0, 8'd0, 2'b00, 7'd3, 32'h0, 8'd10}, nb);
        peek(7'd3, pv);
        chk("R10 byte lane0", pv, 32'h000003EE);
        chk("R3 no busy", 32'(nb), 32'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule